// File: doc/BRIEF.md
# Presettable Binary/Decade Up/Down Digit Chain

This block is a chain of four-bit counting digits. Each digit counts up or down, either over the full binary range 0 to 15 or as a BCD decade 0 to 9. All digits share one clock. An active-low carry-in on each digit acts as its count enable. Each digit drives an active-low carry-out that falls at its terminal count. The carry-out of one digit feeds the carry-in of the next, so a multi-digit value advances as one number. Every digit decodes its own terminal count combinationally. As a result, the carry-in of a higher digit settles in the same cycle as the count below it, and no extra clock is needed to pass the carry along.

A preset input loads the jam bus into every digit. The load is level-sensitive and does not wait for a clock edge. While preset is high, the count outputs show the jam values directly. Clock edges have no effect during this time. The mode select and the direction select are shared by all digits and may change at any time. Tie the chain carry-in low to let the chain run freely, or use it as an enable for the whole chain.

Top module: `updn_digit_chain`

## Requirements
- R1: While `preset_i` is 1, `count_o` equals `jam_i` without waiting for any clock edge, and follows changes of `jam_i`. Digit k occupies bits [4k+3:4k]. An all-zero jam forces a count of zero.
- R2: When `preset_i` falls with `jam_i` held stable, the count keeps the loaded value until the next enabled rising clock edge.
- R3: A digit advances only on a rising clock edge where both its carry-in and `preset_i` are 0. A 1 on `cin_n_i` freezes the whole chain.
- R4: With `bin_sel_i`=1 (binary) and `up_sel_i`=1 (up), a digit increments by one, and 15 wraps to 0.
- R5: With `bin_sel_i`=1 and `up_sel_i`=0 (down), a digit decrements by one, and 0 wraps to 15.
- R6: With `bin_sel_i`=0 (decade), counting up takes 9 to 0, and counting down takes 0 to 9.
- R7: In decade mode, a digit preset to a value from 10 to 15 goes to 0 on the next enabled up count. Counting down from such a value, it decrements by one.
- R8: A digit's carry-out is low only when its carry-in is 0 and its count is at the terminal value: 15 for binary up, 9 for decade up, 0 for down. The carry-out reacts combinationally to the count, the mode and the direction.
- R9: A 1 on a digit's carry-in holds its carry-out at 1, even when the count is at its terminal value.
- R10: Digit k (k>0) takes its carry-in from the carry-out of digit k-1. A two-digit decade chain therefore runs 00 to 99 and wraps to 00. `cout_n_o` is the carry-out of the top digit.
- R11: While `preset_i` is 1, rising clock edges do not change the count, even with the chain enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared rising-edge clock |
| preset_i | input | 1 | Level-sensitive asynchronous load of the jam bus |
| bin_sel_i | input | 1 | 1 = binary modulus 16, 0 = decade modulus 10 |
| up_sel_i | input | 1 | 1 = count up, 0 = count down |
| cin_n_i | input | 1 | Active-low carry-in / enable of the lowest digit |
| jam_i | input | 4*NUM_DIGITS | Parallel load values, digit k in bits [4k+3:4k] |
| count_o | output | 4*NUM_DIGITS | Current count, digit k in bits [4k+3:4k] |
| cout_n_o | output | 1 | Active-low carry-out of the highest digit |

## Verification
Two collisions are exercised. In the first, the preset level and a rising clock edge fall together. The bench holds preset high over several edges with the chain enabled, then expects the jam value to survive unchanged. In the second, a change of direction meets a terminal count. The bench flips `up_sel_i` while the chain sits at 99 in decade up mode, then expects `cout_n_o` to rise before the next edge. Wrap cases in both moduli and both directions, and the sweep through 00 to 99, show that the carry-out of the lower digit enables the upper digit in the same cycle.

// File: rtl/updn_pkg.sv
package updn_pkg;
  localparam int unsigned NIB_W = 4;
  typedef logic [NIB_W-1:0] nib_t;

  localparam nib_t BIN_TOP = nib_t'(15);
  localparam nib_t DEC_TOP = nib_t'(9);
  localparam nib_t NIB_ZERO = nib_t'(0);

  localparam logic SEL_BINARY = 1'b1;
  localparam logic SEL_UP     = 1'b1;
endpackage

// File: rtl/updn_step_logic.sv
module updn_step_logic
  import updn_pkg::*;
(
  input  nib_t cur_i,
  input  logic bin_sel_i,
  input  logic up_sel_i,
  output nib_t nxt_o
);
  nib_t inc_v;
  nib_t dec_v;

  assign inc_v = cur_i + nib_t'(1);
  assign dec_v = cur_i - nib_t'(1);

  always_comb begin
    if (up_sel_i == SEL_UP) begin
      if (bin_sel_i == SEL_BINARY) nxt_o = inc_v;
      else if (cur_i >= DEC_TOP)   nxt_o = NIB_ZERO;
      else                         nxt_o = inc_v;
    end else begin
      if (bin_sel_i == SEL_BINARY)  nxt_o = dec_v;
      else if (cur_i == NIB_ZERO)   nxt_o = DEC_TOP;
      else                          nxt_o = dec_v;
    end
  end
endmodule

// File: rtl/updn_term_detect.sv
module updn_term_detect
  import updn_pkg::*;
(
  input  nib_t cur_i,
  input  logic bin_sel_i,
  input  logic up_sel_i,
  input  logic cin_n_i,
  output logic cout_n_o
);
  nib_t top_v;
  logic at_term;

  assign top_v   = (bin_sel_i == SEL_BINARY) ? BIN_TOP : DEC_TOP;
  assign at_term = (up_sel_i == SEL_UP) ? (cur_i == top_v) : (cur_i == NIB_ZERO);
  assign cout_n_o = cin_n_i | ~at_term;
endmodule

// File: rtl/updn_digit.sv
module updn_digit
  import updn_pkg::*;
(
  input  logic clk,
  input  logic preset_i,
  input  logic bin_sel_i,
  input  logic up_sel_i,
  input  logic cin_n_i,
  input  nib_t jam_i,
  output nib_t q_o,
  output logic cout_n_o
);
  nib_t cnt_q;
  nib_t cnt_nxt;

  updn_step_logic u_step (
    .cur_i     (cnt_q),
    .bin_sel_i (bin_sel_i),
    .up_sel_i  (up_sel_i),
    .nxt_o     (cnt_nxt)
  );

  always_ff @(posedge clk or posedge preset_i) begin
    if (preset_i)      cnt_q <= jam_i;
    else if (!cin_n_i) cnt_q <= cnt_nxt;
  end

  assign q_o = preset_i ? jam_i : cnt_q;

  updn_term_detect u_term (
    .cur_i     (q_o),
    .bin_sel_i (bin_sel_i),
    .up_sel_i  (up_sel_i),
    .cin_n_i   (cin_n_i),
    .cout_n_o  (cout_n_o)
  );

  AST_HOLD_WHEN_INHIBIT: assert property (@(posedge clk) disable iff (preset_i)
    cin_n_i |=> $stable(cnt_q)); // R3
  AST_BIN_UP_STEP: assert property (@(posedge clk) disable iff (preset_i)
    (!cin_n_i && bin_sel_i && up_sel_i) |=> (cnt_q == $past(cnt_q) + nib_t'(1))); // R4
  AST_BIN_DOWN_STEP: assert property (@(posedge clk) disable iff (preset_i)
    (!cin_n_i && bin_sel_i && !up_sel_i) |=> (cnt_q == $past(cnt_q) - nib_t'(1))); // R5
  AST_DEC_IN_RANGE: assert property (@(posedge clk) disable iff (preset_i)
    (!cin_n_i && !bin_sel_i && cnt_q <= DEC_TOP) |=> (cnt_q <= DEC_TOP)); // R6
endmodule

// File: rtl/updn_digit_chain.sv
module updn_digit_chain
  import updn_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 2
) (
  input  logic                          clk,
  input  logic                          preset_i,
  input  logic                          bin_sel_i,
  input  logic                          up_sel_i,
  input  logic                          cin_n_i,
  input  logic [NUM_DIGITS*NIB_W-1:0]   jam_i,
  output logic [NUM_DIGITS*NIB_W-1:0]   count_o,
  output logic                          cout_n_o
);
  localparam int unsigned CNT_W = NUM_DIGITS * NIB_W;

  logic [NUM_DIGITS:0] carry_n;

  assign carry_n[0] = cin_n_i;
  assign cout_n_o   = carry_n[NUM_DIGITS];

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_digit
    nib_t q_k;

    updn_digit u_digit (
      .clk       (clk),
      .preset_i  (preset_i),
      .bin_sel_i (bin_sel_i),
      .up_sel_i  (up_sel_i),
      .cin_n_i   (carry_n[k]),
      .jam_i     (jam_i[k*NIB_W +: NIB_W]),
      .q_o       (q_k),
      .cout_n_o  (carry_n[k+1])
    );

    assign count_o[k*NIB_W +: NIB_W] = q_k;

    if (k > 0) begin : g_link_chk
      AST_UPPER_WAITS_FOR_CARRY: assert property (@(posedge clk) disable iff (preset_i)
        carry_n[k] |=> $stable(count_o[k*NIB_W +: NIB_W])); // R10
    end
  end

  AST_CHAIN_WIDTH: assert property (@(posedge clk) disable iff (preset_i)
    cin_n_i |=> $stable(count_o[CNT_W-1:0])); // R3
endmodule

// File: tb/test_updn_digit_chain.sv
module test_updn_digit_chain;
  logic       clk = 1'b0;
  logic       preset = 1'b1;
  logic       bin_sel = 1'b1;
  logic       up_sel = 1'b1;
  logic       cin_n = 1'b1;
  logic [7:0] jam = 8'h00;
  logic [7:0] count;
  logic       cout_n;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  updn_digit_chain #(.NUM_DIGITS(2)) i_updn_digit_chain (
    .clk       (clk),
    .preset_i  (preset),
    .bin_sel_i (bin_sel),
    .up_sel_i  (up_sel),
    .cin_n_i   (cin_n),
    .jam_i     (jam),
    .count_o   (count),
    .cout_n_o  (cout_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // preset is held across one clock edge so the load spans a sampled edge
  task automatic load(input logic [7:0] v);
    jam = v;
    preset = 1'b1;
    step(1);
    preset = 1'b0;
    #1;
  endtask

  task automatic t_reset_state;
    #1;
    chk("R1 zero jam forces zero", count, 8'h00);
    chk("R9 carry idle while cin high", cout_n, 1'b1);
  endtask

  task automatic t_async_preset;
    step(1);
    jam = 8'h37;
    #1;
    chk("R1 preset follows jam without edge", count, 8'h37);
    jam = 8'h52;
    #1;
    chk("R1 preset follows jam change", count, 8'h52);
    step(1);
    preset = 1'b0;
    #1;
    chk("R2 value kept after preset falls", count, 8'h52);
  endtask

  task automatic t_preset_over_clock;
    bin_sel = 1'b1; up_sel = 1'b1;
    jam = 8'h45; preset = 1'b1; cin_n = 1'b0;
    step(3);
    chk("R11 clock ignored under preset", count, 8'h45);
    cin_n = 1'b1;
    preset = 1'b0;
    #1;
    chk("R2 loaded value held", count, 8'h45);
    step(3);
    chk("R3 cin high freezes count", count, 8'h45);
  endtask

  task automatic t_binary_up;
    bin_sel = 1'b1; up_sel = 1'b1; cin_n = 1'b0;
    load(8'h0E);
    step(1);
    chk("R4 binary increment", count, 8'h0F);
    chk("R8 upper digit not terminal", cout_n, 1'b1);
    step(1);
    chk("R4 R10 low digit wraps, carry into upper", count, 8'h10);
    load(8'hFF);
    chk("R8 binary up terminal 15", cout_n, 1'b0);
    step(1);
    chk("R4 15 wraps to 0", count, 8'h00);
  endtask

  task automatic t_binary_down;
    bin_sel = 1'b1; up_sel = 1'b0; cin_n = 1'b0;
    load(8'h10);
    step(1);
    chk("R5 binary borrow", count, 8'h0F);
    load(8'h00);
    chk("R8 down terminal 0", cout_n, 1'b0);
    step(1);
    chk("R5 0 wraps to 15", count, 8'hFF);
  endtask

  task automatic t_decade_wraps;
    bin_sel = 1'b0; up_sel = 1'b1; cin_n = 1'b0;
    load(8'h98);
    step(1);
    chk("R6 decade step", count, 8'h99);
    chk("R8 decade up terminal 9", cout_n, 1'b0);
    step(1);
    chk("R6 R10 99 wraps to 00", count, 8'h00);
    up_sel = 1'b0;
    #1;
    chk("R8 decade down terminal 0", cout_n, 1'b0);
    step(1);
    chk("R6 00 wraps to 99", count, 8'h99);
  endtask

  task automatic t_decade_out_of_range;
    bin_sel = 1'b0; up_sel = 1'b1; cin_n = 1'b0;
    load(8'h0C);
    chk("R8 12 is not a decade terminal", cout_n, 1'b1);
    step(1);
    chk("R7 up from 12 goes to 0", count, 8'h00);
    up_sel = 1'b0;
    load(8'h0C);
    step(1);
    chk("R7 down from 12 goes to 11", count, 8'h0B);
  endtask

  task automatic t_carry_gating;
    bin_sel = 1'b1; up_sel = 1'b1; cin_n = 1'b1;
    load(8'hFF);
    chk("R9 carry high at terminal when cin high", cout_n, 1'b1);
    step(2);
    chk("R3 no advance with cin high", count, 8'hFF);
    cin_n = 1'b0;
    #1;
    chk("R8 carry falls once cin low", cout_n, 1'b0);
  endtask

  task automatic t_dir_switch;
    bin_sel = 1'b0; up_sel = 1'b1; cin_n = 1'b0;
    load(8'h99);
    chk("R8 terminal 99 up", cout_n, 1'b0);
    up_sel = 1'b0;
    #1;
    chk("R8 direction change releases carry same cycle", cout_n, 1'b1);
    step(1);
    chk("R6 down from 99", count, 8'h98);
  endtask

  task automatic t_decade_sweep;
    bin_sel = 1'b0; up_sel = 1'b1; cin_n = 1'b0;
    load(8'h00);
    step(100);
    chk("R10 hundred counts return to 00", count, 8'h00);
    step(37);
    chk("R10 two-digit decade value", count, 8'h37);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset_state();
    t_async_preset();
    t_preset_over_clock();
    t_binary_up();
    t_binary_down();
    t_decade_wraps();
    t_decade_out_of_range();
    t_carry_gating();
    t_dir_switch();
    t_decade_sweep();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule